// File: doc/BRIEF.md
# Quadrature and Single-Input Pulse Counter

This block counts pulses on two inputs, `in_a` and `in_b`, which are already synchronised to `clk`. It keeps a main counter that moves up or down and wraps against a programmable ceiling. It also keeps an auxiliary counter that only moves up. The control word sets the mode. In the single-input modes the block counts one chosen edge of `in_a`, and the direction comes from a control bit or from the level of `in_b`. In the quadrature modes the two inputs are decoded as a phase pair at one, two or four counts per cycle.

Each edge is found by comparing an input with a copy of it delayed by one cycle. A counting edge moves the counters at the next rising clock edge. There is no data stream: all pins are plain levels, and the control word and ceiling are sampled on every cycle. Two selector fields decide which up events and which down events reach each counter.

Top module: `pulse_quad_counter`

## Requirements
- R1: `ctrl` bits [2:0] select the mode. Values 0 and 7 disable counting, and neither counter changes while disabled. Field positions: [4:3] main selector, [6:5] auxiliary selector, [7] fixed direction (1 = down), [8] direction from `in_b`, [9] edge choice (1 = falling).
- R2: While `rst_n` is low, `count` and `aux_count` are 0 and `ovf` and `unf` are low.
- R3: Modes 1 and 2 count each rising edge of `in_a`, or each falling edge when bit 9 is set. A counting edge changes `count` at the first rising clock edge at which `in_a` differs from its value one cycle earlier.
- R4: In modes 1 and 2, if bit 8 is clear the direction is down when bit 7 is 1 and up otherwise. If bit 8 is set the direction is down while `in_b` is high and up while it is low.
- R5: Mode 3 counts each rising edge of `in_a`: down if `in_b` is high, up if it is low.
- R6: Modes 4, 5 and 6 decode a quadrature pair. A sequence with `in_a` leading (ab = 00,10,11,01) counts up and the reverse counts down. Mode 4 counts only rising `in_a` edges (one per cycle). Mode 5 counts both `in_a` edges (two per cycle). Mode 6 counts every edge of either input (four per cycle).
- R7: In modes 4 to 6, a cycle in which both inputs change at once produces no count.
- R8: The main selector works as follows: 0 applies both up and down events, 1 applies only up events, 2 applies only down events, 3 applies none.
- R9: The auxiliary selector works as follows: 0 never counts, 1 adds one on up events, 2 adds one on down events, 3 adds one on either. The auxiliary counter never decrements and wraps from all-ones to 0.
- R10: An up step from `count == top_val` loads 0. `ovf` is high for exactly that one cycle.
- R11: A down step from `count == 0` loads `top_val`. `unf` is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | 1 | First pulse input (counted input / leading phase) |
| in_b | input | 1 | Second pulse input (direction / second phase) |
| ctrl | input | 10 | Control word, fields as in R1 |
| top_val | input | CNT_W | Wrap ceiling of the main counter |
| count | output | CNT_W | Main counter value |
| aux_count | output | CNT_W | Auxiliary counter value |
| ovf | output | 1 | One-cycle pulse on wrap from ceiling to 0 |
| unf | output | 1 | One-cycle pulse on wrap from 0 to ceiling |

## Verification
Some properties are checked on every cycle: the counters stay still while the block is disabled, while the main selector is "none", or after a dual-input change in the quadrature modes. The auxiliary counter only ever moves up by one. `ovf` and `unf` are never high together, and each lands on the correct wrap value. The right count per edge for each mode, the edge choice, the direction source and the quadrature resolution cannot be shown by the properties. These are shown only by the bench scenarios, which drive pulse trains and phase sequences and compare the results with a behavioural model on every clock.

// File: rtl/pcq_pkg.sv
package pcq_pkg;
  localparam int CTRL_W = 10;

  localparam logic [2:0] MD_OFF        = 3'd0;
  localparam logic [2:0] MD_SINGLE_OVS = 3'd1;
  localparam logic [2:0] MD_SINGLE_EXT = 3'd2;
  localparam logic [2:0] MD_QUAD_EXT   = 3'd3;
  localparam logic [2:0] MD_QUAD_X1    = 3'd4;
  localparam logic [2:0] MD_QUAD_X2    = 3'd5;
  localparam logic [2:0] MD_QUAD_X4    = 3'd6;

  localparam logic [1:0] SEL_MAIN_BOTH = 2'd0;
  localparam logic [1:0] SEL_MAIN_UP   = 2'd1;
  localparam logic [1:0] SEL_MAIN_DN   = 2'd2;

  typedef struct packed {
    logic       fall_edge;
    logic       dir_from_b;
    logic       dir_down;
    logic [1:0] aux_sel;
    logic [1:0] main_sel;
    logic [2:0] mode;
  } ctrl_t;
endpackage

// File: rtl/pcq_event_gen.sv
module pcq_event_gen
  import pcq_pkg::*;
(
  input  logic       clk,
  input  logic       in_a,
  input  logic       in_b,
  input  logic [2:0] mode,
  input  logic       fall_edge,
  input  logic       dir_from_b,
  input  logic       dir_down,
  output logic       ev_up,
  output logic       ev_dn
);
  logic a_q, b_q;
  logic a_chg, b_chg, a_rise, a_fall, quad_up;
  logic hit, down;

  // previous-sample copies; they track the inputs at all times so that
  // a mode change never sees a stale edge
  always_ff @(posedge clk) begin
    a_q <= in_a;
    b_q <= in_b;
  end

  assign a_chg   = in_a ^ a_q;
  assign b_chg   = in_b ^ b_q;
  assign a_rise  = in_a & ~a_q;
  assign a_fall  = ~in_a & a_q;
  // phase rule: a leads b when the new a differs from the old b
  assign quad_up = in_a ^ b_q;

  always_comb begin
    hit  = 1'b0;
    down = 1'b0;
    unique case (mode)
      MD_SINGLE_OVS, MD_SINGLE_EXT: begin
        hit  = fall_edge ? a_fall : a_rise;
        down = dir_from_b ? in_b : dir_down;
      end
      MD_QUAD_EXT: begin
        hit  = a_rise;
        down = in_b;
      end
      MD_QUAD_X1: begin
        hit  = a_rise & ~b_chg;
        down = ~quad_up;
      end
      MD_QUAD_X2: begin
        hit  = a_chg & ~b_chg;
        down = ~quad_up;
      end
      MD_QUAD_X4: begin
        hit  = a_chg ^ b_chg;
        down = ~quad_up;
      end
      default: begin
        hit  = 1'b0;
        down = 1'b0;
      end
    endcase
  end

  assign ev_up = hit & ~down;
  assign ev_dn = hit & down;
endmodule

// File: rtl/pcq_main_counter.sv
module pcq_main_counter
  import pcq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_up,
  input  logic             ev_dn,
  input  logic [1:0]       sel,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             unf
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic do_up, do_dn;

  assign do_up = ev_up & ((sel == SEL_MAIN_BOTH) | (sel == SEL_MAIN_UP));
  assign do_dn = ev_dn & ((sel == SEL_MAIN_BOTH) | (sel == SEL_MAIN_DN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      ovf <= 1'b0;
      unf <= 1'b0;
      if (do_up) begin
        if (cnt == top) begin
          cnt <= '0;
          ovf <= 1'b1;
        end else begin
          cnt <= cnt + ONE;
        end
      end else if (do_dn) begin
        if (cnt == '0) begin
          cnt <= top;
          unf <= 1'b1;
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/pcq_aux_counter.sv
module pcq_aux_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_up,
  input  logic             ev_dn,
  input  logic [1:0]       sel,
  output logic [CNT_W-1:0] cnt
);
  logic inc;
  // bit 0 of the selector admits up events, bit 1 admits down events
  assign inc = (ev_up & sel[0]) | (ev_dn & sel[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (inc) cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/pulse_quad_counter.sv
module pulse_quad_counter
  import pcq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_a,
  input  logic              in_b,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [CNT_W-1:0]  top_val,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  aux_count,
  output logic              ovf,
  output logic              unf
);
  ctrl_t cw;
  logic  ev_up, ev_dn;

  assign cw = ctrl_t'(ctrl);

  pcq_event_gen u_evt (
    .clk        (clk),
    .in_a       (in_a),
    .in_b       (in_b),
    .mode       (cw.mode),
    .fall_edge  (cw.fall_edge),
    .dir_from_b (cw.dir_from_b),
    .dir_down   (cw.dir_down),
    .ev_up      (ev_up),
    .ev_dn      (ev_dn)
  );

  pcq_main_counter #(.CNT_W(CNT_W)) u_main (
    .clk   (clk),
    .rst_n (rst_n),
    .ev_up (ev_up),
    .ev_dn (ev_dn),
    .sel   (cw.main_sel),
    .top   (top_val),
    .cnt   (count),
    .ovf   (ovf),
    .unf   (unf)
  );

  pcq_aux_counter #(.CNT_W(CNT_W)) u_aux (
    .clk   (clk),
    .rst_n (rst_n),
    .ev_up (ev_up),
    .ev_dn (ev_dn),
    .sel   (cw.aux_sel),
    .cnt   (aux_count)
  );
endmodule

// File: rtl/pcq_checker.sv
module pcq_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_a,
  input logic             in_b,
  input logic [9:0]       ctrl,
  input logic [CNT_W-1:0] top_val,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] aux_count,
  input logic             ovf,
  input logic             unf
);
  // R1: a disabled mode in the updating cycle leaves both counters still
  a_r1_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl[2:0]) == 3'd0 || $past(ctrl[2:0]) == 3'd7)
      |-> ($stable(count) && $stable(aux_count)));

  // R7: both inputs changing together in a quadrature mode gives no count
  a_r7_dual_change_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl[2:0]) >= 3'd4 && $past(ctrl[2:0]) <= 3'd6 &&
     $past(in_a) != $past(in_a, 2) && $past(in_b) != $past(in_b, 2))
      |-> ($stable(count) && $stable(aux_count)));

  // R8: selector "none" freezes the main counter
  a_r8_none_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl[4:3]) == 2'd3) |-> $stable(count));

  // R9: the auxiliary counter only steps up by one
  a_r9_aux_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(aux_count) |-> (aux_count == CNT_W'($past(aux_count) + 1'b1)));

  // R10: overflow pulse coincides with the counter at zero
  a_r10_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (count == '0));

  // R11: underflow pulse coincides with the counter at the ceiling
  a_r11_unf_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> (count == $past(top_val)));

  // R10, R11: the two wrap pulses never coincide
  a_r10_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));
endmodule

bind pulse_quad_counter pcq_checker #(.CNT_W(CNT_W)) u_pcq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_a      (in_a),
  .in_b      (in_b),
  .ctrl      (ctrl),
  .top_val   (top_val),
  .count     (count),
  .aux_count (aux_count),
  .ovf       (ovf),
  .unf       (unf)
);

// File: tb/tb_pulse_quad_counter.sv
module tb_pulse_quad_counter;
  localparam int W = 16;
  localparam int WATCHDOG_CYC = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_a = 1'b0;
  logic         in_b = 1'b0;
  logic [9:0]   ctrl = '0;
  logic [W-1:0] top_val = W'(20);
  logic [W-1:0] count, aux_count;
  logic         ovf, unf;

  int checks = 0;
  int fails  = 0;
  bit live   = 0;
  string cur_req = "R2";

  // behavioural reference state
  int m_cnt = 0, m_aux = 0;
  bit m_ovf = 0, m_unf = 0;
  bit pa = 0, pb = 0;

  pulse_quad_counter #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .ctrl(ctrl),
    .top_val(top_val), .count(count), .aux_count(aux_count),
    .ovf(ovf), .unf(unf)
  );

  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [9:0] mk(int md, int msel, int asel, bit ddn, bit dfb, bit fall);
    return {fall, dfb, ddn, 2'(asel), 2'(msel), 3'(md)};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: one update per rising edge
  always @(posedge clk) begin
    int md; bit hit, dn, up_ok, dn_ok;
    md = int'(ctrl[2:0]);
    hit = 0; dn = 0;
    m_ovf = 0; m_unf = 0;
    if (!rst_n) begin
      m_cnt = 0; m_aux = 0;
    end else begin
      if (md == 1 || md == 2) begin
        hit = ctrl[9] ? (pa && !in_a) : (!pa && in_a);
        dn  = ctrl[8] ? in_b : ctrl[7];
      end else if (md == 3) begin
        hit = !pa && in_a;
        dn  = in_b;
      end else if (md >= 4 && md <= 6) begin
        if (in_a != pa && in_b != pb) hit = 0;
        else if (md == 4) hit = !pa && in_a;
        else if (md == 5) hit = (in_a != pa);
        else hit = (in_a != pa) || (in_b != pb);
        // forward sequence 00,10,11,01 counts up
        dn = !(in_a ^ pb);
      end
      up_ok = (ctrl[4:3] == 0 || ctrl[4:3] == 1);
      dn_ok = (ctrl[4:3] == 0 || ctrl[4:3] == 2);
      if (hit && !dn && up_ok) begin
        if (m_cnt == int'(top_val)) begin m_cnt = 0; m_ovf = 1; end
        else m_cnt = m_cnt + 1;
      end else if (hit && dn && dn_ok) begin
        if (m_cnt == 0) begin m_cnt = int'(top_val); m_unf = 1; end
        else m_cnt = m_cnt - 1;
      end
      if (hit && ((!dn && ctrl[5]) || (dn && ctrl[6])))
        m_aux = (m_aux + 1) % (1 << W);
    end
    pa = in_a; pb = in_b;
  end

  // compare on every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (live) begin
      chk({cur_req, " count"}, int'(count), m_cnt);
      chk({cur_req, " aux_count"}, int'(aux_count), m_aux);
      chk({cur_req, " ovf"}, int'(ovf), int'(m_ovf));
      chk({cur_req, " unf"}, int'(unf), int'(m_unf));
    end
  end

  task automatic step(bit a, bit b);
    @(negedge clk); #1;
    in_a = a; in_b = b;
  endtask

  task automatic pulse(bit b);
    step(1'b1, b);
    step(1'b0, b);
  endtask

  task automatic settle();
    @(posedge clk); #3;
  endtask

  task automatic set_ctrl(logic [9:0] v);
    @(negedge clk); #1;
    ctrl = v;
  endtask

  task automatic quad_fwd();
    step(1,0); step(1,1); step(0,1); step(0,0);
  endtask

  task automatic quad_rev();
    step(0,1); step(1,1); step(1,0); step(0,0);
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #2;
    chk("R2 reset count", int'(count), 0);
    chk("R2 reset aux", int'(aux_count), 0);
    chk("R2 reset flags", int'({ovf, unf}), 0);
    @(negedge clk); #1; rst_n = 1'b1;
    live = 1;

    cur_req = "R1";
    pulse(0); pulse(0); settle();
    chk("R1 mode 0 holds", int'(count), 0);
    set_ctrl(mk(7, 0, 3, 0, 0, 0));
    pulse(0); pulse(0); settle();
    chk("R1 mode 7 holds", int'(count), 0);

    cur_req = "R3";
    set_ctrl(mk(1, 0, 3, 0, 0, 0));
    repeat (5) pulse(0);
    settle();
    chk("R3 rising edges up", int'(count), 5);
    chk("R9 aux both", int'(aux_count), 5);
    set_ctrl(mk(2, 0, 3, 0, 0, 1));
    step(1,0); settle();
    chk("R3 rising ignored when falling chosen", int'(count), 5);
    step(0,0); settle();
    chk("R3 falling edge counts", int'(count), 6);

    cur_req = "R4";
    set_ctrl(mk(1, 0, 3, 1, 0, 0));
    pulse(0); pulse(0); settle();
    chk("R4 fixed down", int'(count), 4);
    set_ctrl(mk(1, 0, 3, 0, 1, 0));
    pulse(1); settle();
    chk("R4 in_b high down", int'(count), 3);
    step(0,0); pulse(0); pulse(0); settle();
    chk("R4 in_b low up", int'(count), 5);

    cur_req = "R5";
    set_ctrl(mk(3, 0, 3, 1, 0, 0));
    pulse(0); pulse(0); settle();
    chk("R5 ext quad up", int'(count), 7);
    pulse(1); step(0,0); settle();
    chk("R5 ext quad down", int'(count), 6);

    cur_req = "R6";
    set_ctrl(mk(6, 0, 3, 0, 0, 0));
    quad_fwd(); settle();
    chk("R6 4x forward", int'(count), 10);
    quad_rev(); settle();
    chk("R6 4x reverse", int'(count), 6);
    set_ctrl(mk(5, 0, 3, 0, 0, 0));
    quad_fwd(); settle();
    chk("R6 2x forward", int'(count), 8);
    set_ctrl(mk(4, 0, 3, 0, 0, 0));
    quad_fwd(); settle();
    chk("R6 1x forward", int'(count), 9);
    quad_rev(); settle();
    chk("R6 1x reverse", int'(count), 8);

    cur_req = "R7";
    set_ctrl(mk(6, 0, 3, 0, 0, 0));
    step(1,1); step(0,0); step(1,1); step(0,0); settle();
    chk("R7 dual change no count", int'(count), 8);

    cur_req = "R8";
    set_ctrl(mk(1, 1, 0, 1, 0, 0));
    pulse(0); pulse(0); settle();
    chk("R8 up-only ignores down", int'(count), 8);
    set_ctrl(mk(1, 2, 0, 0, 0, 0));
    pulse(0); settle();
    chk("R8 down-only ignores up", int'(count), 8);
    set_ctrl(mk(1, 3, 0, 0, 0, 0));
    pulse(0); settle();
    chk("R8 none holds", int'(count), 8);
    set_ctrl(mk(1, 2, 0, 1, 0, 0));
    pulse(0); settle();
    chk("R8 down-only applies down", int'(count), 7);

    cur_req = "R9";
    base = int'(aux_count);
    set_ctrl(mk(1, 3, 1, 1, 0, 0));
    pulse(0); settle();
    chk("R9 aux up-only ignores down", int'(aux_count), base);
    set_ctrl(mk(1, 3, 2, 1, 0, 0));
    pulse(0); pulse(0); settle();
    chk("R9 aux counts down events upward", int'(aux_count), base + 2);
    set_ctrl(mk(1, 3, 1, 0, 0, 0));
    pulse(0); settle();
    chk("R9 aux up events", int'(aux_count), base + 3);

    cur_req = "R10";
    set_ctrl(mk(1, 0, 0, 0, 0, 0));
    repeat (13) pulse(0);
    settle();
    chk("R10 reached top", int'(count), 20);
    step(1,0);
    @(posedge clk); #2;
    chk("R10 wrap to zero", int'(count), 0);
    chk("R10 ovf pulse", int'(ovf), 1);
    step(0,0); settle();
    chk("R10 ovf one cycle", int'(ovf), 0);

    cur_req = "R11";
    set_ctrl(mk(1, 0, 0, 1, 0, 0));
    step(1,0);
    @(posedge clk); #2;
    chk("R11 wrap to top", int'(count), 20);
    chk("R11 unf pulse", int'(unf), 1);
    step(0,0); settle();
    chk("R11 unf one cycle", int'(unf), 0);

    repeat (3) @(posedge clk);
    #3;
    live = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule